// File: doc/BRIEF.md
# Doorbell Interrupt Combiner

This block gathers the acknowledge or transfer requests raised by up to 128 doorbell channel windows and merges them into one interrupt line towards the processor. Each window supplies a request bit and a combine-enable bit. Only a window whose combine enable is set can reach the merged line. Software identifies the raising window by reading a bank of four 32-bit combined status words, in which channel `n` appears in word `n / 32` at bit `n % 32`.

The block also presents a small control page. It contains a frame-kind identifier, a feature word that advertises doorbell support, an architecture revision word, a channel-count word and one control bit. Software sets the control bit to keep the frame operational and clears it on teardown. The status words are read-only views of the enabled requests and have no read side effects. A request is cleared only at the window that raised it.

Top module: `dbell_irq_combiner`

## Requirements
- R1: Status word `w` (address 8+w, w = 0..3) bit `b` reads 1 exactly when channel `32*w+b` has its request and its combine enable both high. It changes in the same cycle as the inputs.
- R2: A window whose combine enable is low contributes nothing to either the status words or `combined_irq`.
- R3: Status bits for channel indices at or above `NUM_CH` always read 0.
- R4: `combined_irq` is high exactly when at least one status bit is high.
- R5: The channel-count word (address 2) holds `NUM_CH-1` in bits 7:0. All of its other bits are 0.
- R6: The frame-kind word (address 0) holds `FRAME_KIND` in bits 3:0, where 0 means sender and 1 means receiver. All of its other bits are 0.
- R7: The feature word (address 1) holds `DB_FEATURE` in bits 3:0. The revision word (address 3) holds `ARCH_MINOR` in bits 3:0 and the major revision 2 in bits 7:4.
- R8: The control word (address 4) bit 0 resets to 0 and takes `reg_wdata[0]` on the clock edge of a write. `op_active` mirrors this bit. The other bits of the control word read 0.
- R9: Reading a status word has no side effect. A status bit stays set across repeated reads and falls only when its request or enable falls.
- R10: Writes to any address other than 4 change nothing. Addresses that have no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_irq | input | NUM_CH | Per-window request |
| comb_en | input | NUM_CH | Per-window combine enable |
| reg_addr | input | 4 | Register word address |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on `reg_addr` |
| combined_irq | output | 1 | Merged interrupt |
| op_active | output | 1 | Operational request bit |

## Verification
The bench aims at the word boundaries of the channel map: channels 31 and 32 together, channel 0, and the last implemented channel 99. A design that sliced the words wrongly would put these bits in the wrong word or at the wrong position. It pairs a raised request with a low enable, which a design that ignored the enable would report as pending. It raises every request at once, so any design that leaked into the unimplemented top bits of word 3 would show them. It also rereads a status word and then drops the request, which exposes a design that latches or clears status on a read. Finally, it writes to read-only and unused addresses, which exposes decoding that lets those writes through.

// File: rtl/dbell_irq_combiner.sv
module dbell_irq_combiner #(
  parameter int          NUM_CH     = 100,
  parameter logic [3:0]  FRAME_KIND = 4'd0,
  parameter logic [3:0]  DB_FEATURE = 4'd1,
  parameter logic [3:0]  ARCH_MINOR = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] win_irq,
  input  logic [NUM_CH-1:0] comb_en,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              combined_irq,
  output logic              op_active
);
  localparam int MAX_CH = 128;
  localparam int WORDS  = MAX_CH / 32;
  localparam logic [3:0] ARCH_MAJOR = 4'd2;
  localparam logic [3:0] A_ID = 4'd0, A_FEAT = 4'd1, A_CNT = 4'd2,
                         A_ARCH = 4'd3, A_CTRL = 4'd4, A_ST0 = 4'd8;
  localparam logic [MAX_CH-1:0] IMPL_MASK =
    (NUM_CH >= MAX_CH) ? '1 : ((MAX_CH'(1) << NUM_CH) - MAX_CH'(1));

  logic [MAX_CH-1:0] hit;
  logic [31:0]       stat [WORDS];
  logic [MAX_CH-1:0] stat_flat;
  logic              unused_wdata;

  assign hit          = MAX_CH'(win_irq & comb_en);
  assign combined_irq = |(win_irq & comb_en);
  assign unused_wdata = ^reg_wdata[31:1];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign stat[w] = hit[w*32 +: 32];
    assign stat_flat[w*32 +: 32] = stat[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          op_active <= 1'b0;
    else if (reg_wen && reg_addr == A_CTRL) op_active <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ID:   reg_rdata[3:0] = FRAME_KIND;
      A_FEAT: reg_rdata[3:0] = DB_FEATURE;
      A_CNT:  reg_rdata[7:0] = 8'(NUM_CH - 1);
      A_ARCH: reg_rdata[7:0] = {ARCH_MAJOR, ARCH_MINOR};
      A_CTRL: reg_rdata[0]   = op_active;
      A_ST0, A_ST0 + 4'd1, A_ST0 + 4'd2, A_ST0 + 4'd3:
              reg_rdata = stat[reg_addr[1:0]];
      default: reg_rdata = '0;
    endcase
  end

  assert_unimpl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flat & ~IMPL_MASK) == '0);

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flat & MAX_CH'(~comb_en)) == '0);

  assert_irq_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    combined_irq == (stat_flat != '0));

  assert_ctrl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == A_CTRL) |=> (op_active == $past(reg_wdata[0])));

  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && reg_addr == A_CTRL) |=> $stable(op_active));
endmodule

// File: tb/dbell_irq_combiner_test.sv
module dbell_irq_combiner_test;
  localparam int N = 100;
  localparam int NV = 7;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] win_irq = '0, comb_en = '0;
  logic [3:0] reg_addr = '0;
  logic reg_wen = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic combined_irq, op_active;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbell_irq_combiner #(.NUM_CH(N), .FRAME_KIND(4'd1), .DB_FEATURE(4'd1), .ARCH_MINOR(4'd3)) uut (
    .clk(clk), .rst_n(rst_n), .win_irq(win_irq), .comb_en(comb_en),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .combined_irq(combined_irq), .op_active(op_active));

  localparam logic [N-1:0] V_IRQ [NV] = '{
    '0, '1, N'(1), (N'(1) << 31) | (N'(1) << 32), N'(1) << 99,
    (N'(1) << 64) | (N'(1) << 65), '1 };
  localparam logic [N-1:0] V_EN [NV] = '{
    '1, '0, N'(1), '1, N'(1) << 99, N'(1) << 65, '1 };
  localparam logic [127:0] V_EXP [NV] = '{
    128'h0, 128'h0,
    128'h00000000_00000000_00000000_00000001,
    128'h00000000_00000000_00000001_80000000,
    128'h00000008_00000000_00000000_00000000,
    128'h00000000_00000002_00000000_00000000,
    128'h0000000F_FFFFFFFF_FFFFFFFF_FFFFFFFF };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk); reg_wen = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset op_active", 32'(op_active), 0);
    rd(4'd4, d); check("R8 reset ctrl", d, 0);
    rd(4'd0, d); check("R6 frame kind", d, 32'h1);
    rd(4'd1, d); check("R7 feature", d, 32'h1);
    rd(4'd3, d); check("R7 revision", d, 32'h23);
    rd(4'd2, d); check("R5 channel count", d, 32'd99);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      win_irq = V_IRQ[v]; comb_en = V_EN[v];
      for (int w = 0; w < 4; w++) begin
        rd(4'(8 + w), d);
        check("R1/R2/R3 status word", d, V_EXP[v][w*32 +: 32]);
      end
      check("R4 combined_irq", 32'(combined_irq), 32'(V_EXP[v] != 0));
    end

    rd(4'd11, d); check("R3 unimplemented bits of word 3", d & 32'hFFFF_FFF0, 0);

    @(negedge clk); win_irq = N'(1) << 40; comb_en = N'(1) << 40;
    rd(4'd9, d); rd(4'd9, d); check("R9 status survives reread", d, 32'h100);
    @(negedge clk); win_irq = '0;
    rd(4'd9, d); check("R9 status falls at source", d, 0);
    check("R9 irq falls at source", 32'(combined_irq), 0);

    wr(4'd4, 32'h1);
    check("R8 op_active set", 32'(op_active), 1);
    rd(4'd4, d); check("R8 ctrl readback", d, 1);
    wr(4'd2, 32'h0); wr(4'd9, 32'hFFFF_FFFF); wr(4'd5, 32'h0);
    check("R10 op_active unaffected", 32'(op_active), 1);
    rd(4'd2, d); check("R10 count unchanged", d, 32'd99);
    rd(4'd5, d); check("R10 hole reads zero", d, 0);
    rd(4'd9, d); check("R10 status unchanged by write", d, 0);
    wr(4'd4, 32'hFFFF_FFFE);
    check("R8 op_active cleared", 32'(op_active), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule